// File: doc/BRIEF.md
# Tree Search Road Refiner

This block sharpens coarse roads from a pattern matcher into narrower sub-roads. Each incoming road ID names a root entry in an on-chip table. That entry holds a coarse superstrip coordinate per detector layer and a child-valid mask. A child pattern splits every layer's superstrip in half, and the child index carries one bit per layer to say which half. A child that exists in the table survives only if every layer's half-strip holds at least one hit in the current event. A survivor at the first level may then be refined one level further, using a second table that holds a child-valid mask for each first-level node. Hits arrive before the roads of an event. They are kept as a one-bit-per-fine-bin occupancy map for each layer.

Incoming roads wait in a small work queue. One search engine processes them one at a time, depth first, and emits each surviving thin road as a single ID. The ID is the parent road followed by the child index at each level. A shallow-mode input stops the search after the first level. A single-cycle done pulse marks the end of an event. It follows the last thin road produced by the roads that came before, and including, the road flagged as last. The block is therefore a fake-road filter placed in front of track fitting.

Top module: `tree_search_refiner`

## Requirements
- R1: While reset is held and on the first cycle after it, thin_valid and done are low and road_ready is high.
- R2: A hit sets the occupancy bit for (hit_layer, hit_bin). evt_clear empties all occupancy bits. A hit presented in the same cycle as evt_clear is kept, so it belongs to the new event.
- R3: Take a first-level child k of road r. Bit l of k selects the half of layer l. The child survives only when bit k of the root mask of r is set, and, for every layer l, fine bin coarse_l*4 + k[l]*2 + 0 or coarse_l*4 + k[l]*2 + 1 is occupied. A road without survivors emits nothing.
- R4: In deep mode, each surviving child k is refined with the mask stored at second-table address {r, k}. Grandchild j survives only when that mask bit j is set and fine bin coarse_l*4 + k[l]*2 + j[l] is occupied in every layer l. Children that fail R3 are never descended, whatever their stored mask.
- R5: A thin road ID is {road (4 bits), k (4 bits), j (4 bits)}, most significant first. When shallow is 1, the first-level survivors are emitted with j = 0.
- R6: Output order is deterministic. Roads are served in arrival order. Within a road, k ascends, and in deep mode all j of one k come out, in ascending order, before the next k.
- R7: Roads are accepted on cycles with road_valid and road_ready both high. road_ready drops while the queue holds QDEPTH roads, and no accepted road is lost.
- R8: After a road flagged with road_last is accepted, done pulses for exactly one cycle, once every queued road has been fully searched. done is never high in the same cycle as thin_valid.
- R9: A road accepted into an empty queue with an idle engine yields its first thin road 3 cycles after the accepting edge in shallow mode and 5 cycles after it in deep mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_clear | input | 1 | Empty the occupancy map at an event boundary |
| hit_valid | input | 1 | Hit present |
| hit_layer | input | 2 | Layer of the hit |
| hit_bin | input | 4 | Fine bin of the hit |
| shallow | input | 1 | 1: stop the search at the first level; held stable during an event |
| tbl_we | input | 1 | Table write strobe |
| tbl_level | input | 1 | 0: root table (address bits 3:0), 1: second-level mask table |
| tbl_addr | input | 8 | Table address; for the second level it is {road, k} |
| tbl_mask | input | 16 | Child-valid mask to store |
| tbl_coarse | input | 8 | Coarse coordinate of each layer, 2 bits per layer, layer 0 lowest; root table only |
| road_valid | input | 1 | Coarse road offered |
| road_id | input | 4 | Coarse road ID |
| road_last | input | 1 | Offered road is the last of its event |
| road_ready | output | 1 | Work queue can accept a road |
| thin_valid | output | 1 | Thin road present |
| thin_id | output | 12 | Thin road ID {road, k, j} |
| done | output | 1 | End of event pulse |

## Verification
From an idle engine, a thin road is due 3 clock edges after the edge that accepts its road in shallow mode and 5 edges after it in deep mode. done follows the last thin road of the event within 3 edges. The bench drives and samples on falling edges, and counts edges from the accepting edge to check the first-result latency exactly. For longer streams, where queueing shifts the timing, it collects every falling-edge sample of thin_valid and done. It then compares the ordered list of thin roads, and the number seen before done, with the list computed from the requirements.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SCAN1,
    ST_WAIT2,
    ST_SCAN2
  } tsr_state_t;
endpackage

// File: rtl/tsr_occ.sv
module tsr_occ #(
  parameter int NL = 4,
  parameter int FB = 4,
  parameter int LW = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    hit_valid,
  input  logic [LW-1:0]           hit_layer,
  input  logic [FB-1:0]           hit_bin,
  output logic [NL*(1<<FB)-1:0]   occ
);
  localparam int NB = 1 << FB;

  logic [NL*NB-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    if (hit_valid && (int'(hit_layer) < NL))
      set_vec[int'(hit_layer)*NB + int'(hit_bin)] = 1'b1;
  end

  // clear first, then the new hit, so a hit on the clear cycle is kept
  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= (clear ? '0 : occ) | set_vec;
  end
endmodule

// File: rtl/tsr_queue.sv
module tsr_queue #(
  parameter int W = 4,
  parameter int D = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (D > 1) ? $clog2(D) : 1;

  logic [W-1:0]  mem [D];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == (PW+1)'(D));
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push && !full) wp <= (wp == PW'(D-1)) ? '0 : wp + 1'b1;
      if (pop && !empty) rp <= (rp == PW'(D-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (PW+1)'(push && !full) - (PW+1)'(pop && !empty);
    end
  end
endmodule

// File: rtl/tsr_ram.sv
module tsr_ram #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [1<<AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tree_search_refiner.sv
module tree_search_refiner
  import tsr_pkg::*;
#(
  parameter int NL = 4,
  parameter int CW = 2,
  parameter int RW = 4,
  parameter int QDEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  evt_clear,
  input  logic                  hit_valid,
  input  logic [((NL>1)?$clog2(NL):1)-1:0] hit_layer,
  input  logic [CW+1:0]         hit_bin,
  input  logic                  shallow,
  input  logic                  tbl_we,
  input  logic                  tbl_level,
  input  logic [RW+NL-1:0]      tbl_addr,
  input  logic [(1<<NL)-1:0]    tbl_mask,
  input  logic [NL*CW-1:0]      tbl_coarse,
  input  logic                  road_valid,
  input  logic [RW-1:0]         road_id,
  input  logic                  road_last,
  output logic                  road_ready,
  output logic                  thin_valid,
  output logic [RW+2*NL-1:0]    thin_id,
  output logic                  done
);
  localparam int LEVELS = 2;
  localparam int CH  = 1 << NL;
  localparam int FB  = CW + LEVELS;
  localparam int NB  = 1 << FB;
  localparam int LW  = (NL > 1) ? $clog2(NL) : 1;
  localparam int RDW = CH + NL*CW;

  tsr_state_t       st;
  logic [NL*NB-1:0] occ;
  logic             q_empty, q_full, q_push, rd0, rd1;
  logic [RW-1:0]    q_dout, cur_road;
  logic [RDW-1:0]   q0;
  logic [CH-1:0]    q1, surv0, surv1, ok1, ok2;
  logic [NL*CW-1:0] cur_coarse, q0_coarse;
  logic [NL-1:0]    c1, lo0, lo1;
  logic             last_seen;

  tsr_occ #(.NL(NL), .FB(FB), .LW(LW)) u_occ (
    .clk(clk), .rst(rst), .clear(evt_clear), .hit_valid(hit_valid),
    .hit_layer(hit_layer), .hit_bin(hit_bin), .occ(occ)
  );

  assign road_ready = !q_full;
  assign q_push     = road_valid && !q_full;
  assign rd0        = (st == ST_IDLE) && !q_empty;
  assign rd1        = (st == ST_SCAN1) && (surv0 != '0) && !shallow;

  tsr_queue #(.W(RW), .D(QDEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(q_push), .din(road_id), .pop(rd0),
    .dout(q_dout), .empty(q_empty), .full(q_full)
  );

  tsr_ram #(.AW(RW), .DW(RDW)) u_root_tbl (
    .clk(clk), .we(tbl_we && !tbl_level), .waddr(tbl_addr[RW-1:0]),
    .wdata({tbl_coarse, tbl_mask}), .re(rd0), .raddr(q_dout), .rdata(q0)
  );

  tsr_ram #(.AW(RW+NL), .DW(CH)) u_kid_tbl (
    .clk(clk), .we(tbl_we && tbl_level), .waddr(tbl_addr),
    .wdata(tbl_mask), .re(rd1), .raddr({cur_road, lo0}), .rdata(q1)
  );

  assign q0_coarse = q0[CH +: NL*CW];

  // hit coverage of every child at both levels, all children in parallel
  always_comb begin
    ok1 = '1;
    ok2 = '1;
    for (int k = 0; k < CH; k++) begin
      for (int l = 0; l < NL; l++) begin
        ok1[k] = ok1[k] &
          (occ[l*NB + (int'(q0_coarse[l*CW +: CW]) << LEVELS) + ((k >> l) & 1)*2]
         | occ[l*NB + (int'(q0_coarse[l*CW +: CW]) << LEVELS) + ((k >> l) & 1)*2 + 1]);
        ok2[k] = ok2[k] &
          occ[l*NB + (int'(cur_coarse[l*CW +: CW]) << LEVELS) + int'(c1[l])*2 + ((k >> l) & 1)];
      end
    end
  end

  // lowest pending child first gives the depth-first ascending order
  always_comb begin
    lo0 = '0;
    lo1 = '0;
    for (int i = CH-1; i >= 0; i--) begin
      if (surv0[i]) lo0 = NL'(i);
      if (surv1[i]) lo1 = NL'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      thin_valid <= 1'b0;
      thin_id    <= '0;
      done       <= 1'b0;
      last_seen  <= 1'b0;
      cur_road   <= '0;
      cur_coarse <= '0;
      c1         <= '0;
      surv0      <= '0;
      surv1      <= '0;
    end else begin
      thin_valid <= 1'b0;
      done       <= 1'b0;
      if (q_push && road_last) last_seen <= 1'b1;
      case (st)
        ST_IDLE: begin
          if (!q_empty) begin
            cur_road <= q_dout;
            st       <= ST_FETCH;
          end else if (last_seen) begin
            done      <= 1'b1;
            last_seen <= q_push && road_last;
          end
        end
        ST_FETCH: begin
          cur_coarse <= q0_coarse;
          surv0      <= q0[CH-1:0] & ok1;
          st         <= ST_SCAN1;
        end
        ST_SCAN1: begin
          if (surv0 == '0) begin
            st <= ST_IDLE;
          end else begin
            surv0[lo0] <= 1'b0;
            c1         <= lo0;
            if (shallow) begin
              thin_valid <= 1'b1;
              thin_id    <= {cur_road, lo0, {NL{1'b0}}};
            end else begin
              st <= ST_WAIT2;
            end
          end
        end
        ST_WAIT2: begin
          surv1 <= q1 & ok2;
          st    <= ST_SCAN2;
        end
        ST_SCAN2: begin
          if (surv1 == '0) begin
            st <= ST_SCAN1;
          end else begin
            surv1[lo1] <= 1'b0;
            thin_valid <= 1'b1;
            thin_id    <= {cur_road, c1, lo1};
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
  parameter int RW = 4,
  parameter int NL = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               thin_valid,
  input logic               done,
  input logic               shallow,
  input logic [RW+2*NL-1:0] thin_id
);
  localparam int TW = RW + 2*NL;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && thin_valid));

  // R5
  shallow_id_chk: assert property (@(posedge clk) disable iff (rst)
    (thin_valid && shallow) |-> (thin_id[NL-1:0] == '0));

  // R6
  order_chk: assert property (@(posedge clk) disable iff (rst)
    (thin_valid && $past(thin_valid) &&
     (thin_id[TW-1 -: RW] == $past(thin_id[TW-1 -: RW])))
    |-> (thin_id > $past(thin_id)));
endmodule

bind tree_search_refiner tsr_checker #(.RW(RW), .NL(NL)) u_chk (
  .clk(clk), .rst(rst), .thin_valid(thin_valid), .done(done),
  .shallow(shallow), .thin_id(thin_id)
);

// File: tb/test_tree_search_refiner.sv
`timescale 1ns/1ps
module test_tree_search_refiner;
  localparam int NL = 4, CW = 2, RW = 4, QD = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic evt_clear = 0, hit_valid = 0, shallow = 0, tbl_we = 0, tbl_level = 0;
  logic [1:0] hit_layer = '0;
  logic [3:0] hit_bin = '0;
  logic [7:0] tbl_addr = '0;
  logic [15:0] tbl_mask = '0;
  logic [7:0] tbl_coarse = '0;
  logic road_valid = 0, road_last = 0;
  logic [3:0] road_id = '0;
  logic road_ready, thin_valid, done;
  logic [11:0] thin_id;

  tree_search_refiner #(.NL(NL), .CW(CW), .RW(RW), .QDEPTH(QD)) i_tree_search_refiner (
    .clk(clk), .rst(rst), .evt_clear(evt_clear), .hit_valid(hit_valid),
    .hit_layer(hit_layer), .hit_bin(hit_bin), .shallow(shallow),
    .tbl_we(tbl_we), .tbl_level(tbl_level), .tbl_addr(tbl_addr),
    .tbl_mask(tbl_mask), .tbl_coarse(tbl_coarse), .road_valid(road_valid),
    .road_id(road_id), .road_last(road_last), .road_ready(road_ready),
    .thin_valid(thin_valid), .thin_id(thin_id), .done(done)
  );

  always #4 clk = ~clk;

  logic [15:0] m_root [16];
  logic [7:0]  m_coarse [16];
  logic [15:0] m_kid [256];
  logic [15:0] m_occ [4];
  int exp_q[$], got_q[$];
  int roads [16];
  int n_chk = 0, n_fail = 0, done_cnt = 0, got_at_done = -1, cyc = 0;
  bit ready_low = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (thin_valid) got_q.push_back(int'(thin_id));
      if (done) begin
        done_cnt++;
        got_at_done = got_q.size();
      end
      if (!road_ready) ready_low = 1;
    end
  end

  function automatic int bin_of(input int c, input int kb, input int b);
    return c*4 + kb*2 + b;
  endfunction

  function automatic void exp_fill(input int r, input bit sh);
    for (int k = 0; k < 16; k++) begin
      bit ok = m_root[r][k];
      for (int l = 0; l < 4; l++) begin
        int c = int'(m_coarse[r][l*2 +: 2]);
        if (!(m_occ[l][bin_of(c, (k>>l)&1, 0)] || m_occ[l][bin_of(c, (k>>l)&1, 1)])) ok = 0;
      end
      if (ok && sh) exp_q.push_back((r << 8) | (k << 4));
      if (ok && !sh) begin
        for (int j = 0; j < 16; j++) begin
          bit ok2 = m_kid[r*16 + k][j];
          for (int l = 0; l < 4; l++) begin
            int c = int'(m_coarse[r][l*2 +: 2]);
            if (!m_occ[l][c*4 + ((k>>l)&1)*2 + ((j>>l)&1)]) ok2 = 0;
          end
          if (ok2) exp_q.push_back((r << 8) | (k << 4) | j);
        end
      end
    end
  endfunction

  task automatic wr_tbl(input bit lvl, input int addr, input int mask, input int co);
    @(negedge clk);
    tbl_we = 1; tbl_level = lvl; tbl_addr = 8'(addr);
    tbl_mask = 16'(mask); tbl_coarse = 8'(co);
    if (!lvl) begin m_root[addr] = 16'(mask); m_coarse[addr] = 8'(co); end
    else m_kid[addr] = 16'(mask);
  endtask

  task automatic clr(input bit with_hit, input int l, input int b);
    @(negedge clk);
    tbl_we = 0; evt_clear = 1; hit_valid = with_hit;
    hit_layer = 2'(l); hit_bin = 4'(b);
    for (int i = 0; i < 4; i++) m_occ[i] = '0;
    if (with_hit) m_occ[l][b] = 1'b1;
  endtask

  task automatic put_hit(input int l, input int b);
    @(negedge clk);
    tbl_we = 0; evt_clear = 0; hit_valid = 1;
    hit_layer = 2'(l); hit_bin = 4'(b);
    m_occ[l][b] = 1'b1;
  endtask

  task automatic send_road(input int r, input bit last);
    @(negedge clk);
    tbl_we = 0; evt_clear = 0; hit_valid = 0;
    road_valid = 1; road_id = 4'(r); road_last = last;
    while (!road_ready) @(negedge clk);
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (done_cnt == 0 && t < 3000) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
    chk(done_cnt == 1, tag, done_cnt, 1);
  endtask

  task automatic run_event(input bit sh, input int n, input string tag);
    exp_q.delete(); got_q.delete(); done_cnt = 0; got_at_done = -1;
    @(negedge clk);
    hit_valid = 0; evt_clear = 0; tbl_we = 0; shallow = sh;
    for (int i = 0; i < n; i++) exp_fill(roads[i], sh);
    for (int i = 0; i < n; i++) send_road(roads[i], i == n-1);
    @(negedge clk); road_valid = 0;
    wait_done({"R8 single done ", tag});
    chk(got_at_done == exp_q.size(), {"R8 thin count before done ", tag}, got_at_done, exp_q.size());
    chk(got_q.size() == exp_q.size(), {"R3 R4 thin count ", tag}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], {"R5 R6 thin id ", tag}, got_q[i], exp_q[i]);
  endtask

  task automatic lat_test(input bit sh, input int lat, input string tag);
    exp_q.delete(); got_q.delete(); done_cnt = 0; got_at_done = -1;
    @(negedge clk); shallow = sh; hit_valid = 0;
    send_road(13, 1);
    @(negedge clk); road_valid = 0;
    for (int m = 0; m < lat; m++) begin
      chk(!thin_valid, {"R9 not yet ", tag}, thin_valid, 0);
      @(negedge clk);
    end
    chk(thin_valid && thin_id == 12'hD00, {"R9 first thin due ", tag}, int'(thin_id), 32'hD00);
    wait_done({"R8 done after latency road ", tag});
  endtask

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < 4; i++) m_occ[i] = '0;
    repeat (3) @(negedge clk);
    chk(!thin_valid && !done, "R1 outputs low in reset", int'(thin_valid) + int'(done), 0);
    @(negedge clk); rst = 0;
    chk(!thin_valid && !done, "R1 outputs low after reset", int'(thin_valid) + int'(done), 0);
    chk(road_ready, "R1 ready after reset", road_ready, 1);

    for (int r = 0; r < 16; r++) wr_tbl(0, r, $urandom & $urandom, $urandom & 8'hFF);
    for (int a = 0; a < 256; a++) wr_tbl(1, a, $urandom & $urandom, 0);
    wr_tbl(0, 15, 16'h0001, 0);
    wr_tbl(0, 14, 16'h0000, 0);
    wr_tbl(0, 13, 16'h0001, 0);
    wr_tbl(1, 13*16, 16'h0001, 0);
    wr_tbl(0, 12, 16'h0003, 0);
    wr_tbl(1, 12*16, 16'hFFFF, 0);
    wr_tbl(1, 12*16 + 1, 16'hFFFF, 0);

    // R2: hit on the clear cycle is kept
    clr(1, 0, 0);
    for (int l = 1; l < 4; l++) put_hit(l, 1);
    roads[0] = 15; run_event(1, 1, "R2 hit with clear");
    chk(got_q.size() == 1, "R2 clear-cycle hit kept", got_q.size(), 1);
    // R2: clear removes earlier hits
    put_hit(0, 0);
    clr(0, 0, 0);
    for (int l = 1; l < 4; l++) put_hit(l, 1);
    roads[0] = 15; roads[1] = 14; run_event(1, 2, "R2 cleared");
    chk(got_q.size() == 0, "R2 clear empties map", got_q.size(), 0);

    // R4: pruned subtree
    clr(1, 0, 2);
    for (int l = 1; l < 4; l++) put_hit(l, 0);
    roads[0] = 12; run_event(0, 1, "R4 prune");
    chk(got_q.size() == 1 && got_q[0] == 12'hC10, "R4 only surviving subtree", got_q.size() > 0 ? got_q[0] : -1, 32'hC10);

    // R9 latency
    clr(1, 0, 0);
    for (int l = 1; l < 4; l++) put_hit(l, 0);
    lat_test(1, 3, "shallow");
    lat_test(0, 5, "deep");

    // random events
    for (int e = 0; e < 8; e++) begin
      clr(0, 0, 0);
      for (int l = 0; l < 4; l++)
        for (int h = 0; h < 7; h++) put_hit(l, $urandom % 16);
      for (int i = 0; i < 5; i++) roads[i] = $urandom % 16;
      run_event(e[0], 5, "random");
    end

    // R7 burst fills the queue
    clr(0, 0, 0);
    for (int l = 0; l < 4; l++)
      for (int h = 0; h < 9; h++) put_hit(l, $urandom % 16);
    ready_low = 0;
    for (int i = 0; i < 12; i++) roads[i] = $urandom % 16;
    run_event(0, 12, "R7 burst");
    chk(ready_low, "R7 ready drops when queue full", ready_low, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule